// File: doc/BRIEF.md
# CPU Interrupt Cause and Mask Combiner

This block forms the eight interrupt bits of a processor's cause register and reduces them to a single exception request. Six bits come from hardware: five active-low external interrupt pins, and one active-low internal line. The internal line is the already-combined interrupt from the system controller and has no external pin. The top hardware bit is shared: it is set by external pin 5, or by a timer interrupt when the timer was enabled at boot.

The two lowest cause bits are software interrupts. Software sets and clears them through a small write port. The same port loads an eight-bit status mask. Each cause bit is ANDed with its mask bit and the results are ORed together. That OR is registered and driven out as the exception request. The cause value and the mask can be read back at all times.

Cause bit numbering follows the processor convention, bits 15 down to 8. On the ports, bit k of an eight-bit bus stands for cause or mask bit 8+k.

Top module: `cpu_irq_combiner`

## Requirements
- R1: Cause bit 15 (cause_rd[7]) is set when pin_irq_n[4] (external interrupt 5) is low, or when timer_irq is high and the captured boot timer enable is 1.
- R2: Cause bit 14 (cause_rd[6]) is set exactly when pin_irq_n[3] (external interrupt 4) is low.
- R3: Cause bit 13 (cause_rd[5]) is set exactly when the internal line sys_irq_n is low.
- R4: Cause bits 12, 11 and 10 (cause_rd[4:2]) are set exactly when pin_irq_n[2], pin_irq_n[1] and pin_irq_n[0] (external interrupts 2, 1, 0) are low.
- R5: A write with wr_sel=0 loads only the software bits: wr_data[1:0] goes to cause_rd[1:0], and wr_data[7:2] has no effect. The software bits keep their value until the next such write.
- R6: A write with wr_sel=1 loads wr_data into the status mask, read on mask_rd. The mask keeps its value until the next such write.
- R7: exc_req is high exactly when some bit of the cause value is 1 and the matching mask bit is also 1.
- R8: boot_timer_en is sampled only while rst is high. Changes on it after reset has been released have no effect.
- R9: While rst is high, cause_rd, mask_rd and exc_req are all zero.
- R10: A change on any input or write appears on cause_rd, mask_rd and exc_req at the next rising clock edge, and all three update at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot_timer_en is captured while it is high |
| pin_irq_n | input | 5 | Active-low external interrupts; index 0..4 = interrupts 0, 1, 2, 4, 5 |
| sys_irq_n | input | 1 | Active-low internal interrupt from the system controller |
| timer_irq | input | 1 | Timer interrupt, active high |
| boot_timer_en | input | 1 | Boot-time enable for the timer share of cause bit 15 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = software cause bits, 1 = status mask |
| wr_data | input | 8 | Write data; bit k maps to register bit 8+k |
| cause_rd | output | 8 | Registered cause bits 15..8 |
| mask_rd | output | 8 | Status mask bits 15..8 |
| exc_req | output | 1 | Registered exception request |

## Verification
On every cycle, the assertions check four things. The software bits and the mask change only after a write to them. The captured timer enable never moves outside reset. Cause bit 14 follows its pin one cycle late. A request is never raised while the mask is all zero. Only the bench scenarios can show the full mapping of each pin and of the timer share onto its cause bit, and that writes to the hardware-owned bits are discarded. They also show the exact OR of masked bits, and that the boot enable set during reset, rather than any later value, decides whether the timer counts.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CAUSE_W = 8;
    localparam int SW_W    = 2;
    localparam int HW_W    = CAUSE_W - SW_W;
    localparam int PIN_W   = 5;

    typedef enum logic {
        SEL_CAUSE  = 1'b0,
        SEL_STATUS = 1'b1
    } wr_sel_e;

    typedef struct packed {
        logic [HW_W-1:0] hw;
        logic [SW_W-1:0] sw;
    } cause_t;

    typedef struct packed {
        logic          en;
        wr_sel_e       sel;
        logic [CAUSE_W-1:0] data;
    } reg_wr_t;

    // Builds the hardware cause bits from active-low inputs.
    // Result order (MSB first): int5|timer, int4, internal, int2, int1, int0
    function automatic logic [HW_W-1:0] map_hw(
        input logic [PIN_W-1:0] pins_n,
        input logic             sys_n,
        input logic             tmr
    );
        logic [HW_W-1:0] r;
        r[5] = ~pins_n[4] | tmr;
        r[4] = ~pins_n[3];
        r[3] = ~sys_n;
        r[2] = ~pins_n[2];
        r[1] = ~pins_n[1];
        r[0] = ~pins_n[0];
        return r;
    endfunction

endpackage

// File: rtl/irq_hw_sources.sv
module irq_hw_sources
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIN_W-1:0]     pin_irq_n,
    input  logic                 sys_irq_n,
    input  logic                 timer_irq,
    input  logic                 boot_timer_en,
    output logic [HW_W-1:0]      hw_nx,
    output logic [HW_W-1:0]      hw_q
);

    logic timer_en_q;
    logic timer_gated;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_en_q <= boot_timer_en;
        end
    end

    assign timer_gated = timer_irq & timer_en_q;

    always_comb begin
        hw_nx = map_hw(pin_irq_n, sys_irq_n, timer_gated);
    end

    always_ff @(posedge clk) begin
        if (rst) hw_q <= '0;
        else     hw_q <= hw_nx;
    end

    // R8: captured timer enable never changes outside reset
    a_r8_timer_en_fixed: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(timer_en_q));

endmodule

// File: rtl/irq_sw_regs.sv
module irq_sw_regs
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_wr_t              wr,
    output logic [SW_W-1:0]      sw_nx,
    output logic [SW_W-1:0]      sw_q,
    output logic [CAUSE_W-1:0]   mask_nx,
    output logic [CAUSE_W-1:0]   mask_q
);

    logic hit_cause;
    logic hit_status;

    assign hit_cause  = wr.en && (wr.sel == SEL_CAUSE);
    assign hit_status = wr.en && (wr.sel == SEL_STATUS);

    always_comb begin
        sw_nx   = hit_cause  ? wr.data[SW_W-1:0] : sw_q;
        mask_nx = hit_status ? wr.data           : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q   <= '0;
            mask_q <= '0;
        end else begin
            sw_q   <= sw_nx;
            mask_q <= mask_nx;
        end
    end

    // R5: software bits hold unless a cause write occurred
    a_r5_sw_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit_cause)) |-> $stable(sw_q));

    // R6: mask holds unless a status write occurred
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit_status)) |-> $stable(mask_q));

endmodule

// File: rtl/irq_request.sv
module irq_request
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CAUSE_W-1:0]   cause_nx,
    input  logic [CAUSE_W-1:0]   mask_nx,
    input  logic [CAUSE_W-1:0]   mask_q,
    output logic                 exc_req
);

    logic [CAUSE_W-1:0] hit;

    generate
        for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
            assign hit[i] = cause_nx[i] & mask_nx[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) exc_req <= 1'b0;
        else     exc_req <= |hit;
    end

    // R7: no request can be raised while the whole mask is clear
    a_r7_no_req_unmasked: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !exc_req);

endmodule

// File: rtl/cpu_irq_combiner.sv
module cpu_irq_combiner
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [4:0]           pin_irq_n,
    input  logic                 sys_irq_n,
    input  logic                 timer_irq,
    input  logic                 boot_timer_en,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [7:0]           wr_data,
    output logic [7:0]           cause_rd,
    output logic [7:0]           mask_rd,
    output logic                 exc_req
);

    logic [HW_W-1:0]    hw_nx;
    logic [HW_W-1:0]    hw_q;
    logic [SW_W-1:0]    sw_nx;
    logic [SW_W-1:0]    sw_q;
    logic [CAUSE_W-1:0] mask_nx;
    logic [CAUSE_W-1:0] mask_q;
    reg_wr_t            wr;
    cause_t             cause_nx;
    cause_t             cause_q;

    assign wr.en   = wr_en;
    assign wr.sel  = wr_sel_e'(wr_sel);
    assign wr.data = wr_data;

    irq_hw_sources u_hw (
        .clk           (clk),
        .rst           (rst),
        .pin_irq_n     (pin_irq_n),
        .sys_irq_n     (sys_irq_n),
        .timer_irq     (timer_irq),
        .boot_timer_en (boot_timer_en),
        .hw_nx         (hw_nx),
        .hw_q          (hw_q)
    );

    irq_sw_regs u_sw (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .sw_nx   (sw_nx),
        .sw_q    (sw_q),
        .mask_nx (mask_nx),
        .mask_q  (mask_q)
    );

    always_comb begin
        cause_nx.hw = hw_nx;
        cause_nx.sw = sw_nx;
        cause_q.hw  = hw_q;
        cause_q.sw  = sw_q;
    end

    irq_request u_req (
        .clk      (clk),
        .rst      (rst),
        .cause_nx (cause_nx),
        .mask_nx  (mask_nx),
        .mask_q   (mask_q),
        .exc_req  (exc_req)
    );

    assign cause_rd = cause_q;
    assign mask_rd  = mask_q;

    // R2 and R10: cause bit 14 follows its pin one clock later
    a_r2_int4_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cause_rd[6] == !$past(pin_irq_n[3])));

endmodule

// File: tb/tb_cpu_irq_combiner.sv
module tb_cpu_irq_combiner;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] cause;
        logic [7:0] mask;
        logic       req;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] pin_irq_n = 5'h1f;
    logic       sys_irq_n = 1'b1;
    logic       timer_irq = 1'b0;
    logic       boot_timer_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cause_rd;
    logic [7:0] mask_rd;
    logic       exc_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    logic [1:0] m_sw;
    logic [7:0] m_mask;
    logic       m_ten;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_irq_combiner dut (
        .clk(clk), .rst(rst), .pin_irq_n(pin_irq_n), .sys_irq_n(sys_irq_n),
        .timer_irq(timer_irq), .boot_timer_en(boot_timer_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cause_rd(cause_rd),
        .mask_rd(mask_rd), .exc_req(exc_req)
    );

    task automatic do_reset(input logic ben, input string tag);
        @(negedge clk);
        rst = 1'b1; boot_timer_en = ben; wr_en = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        checks++;
        if (cause_rd !== 8'h00 || mask_rd !== 8'h00 || exc_req !== 1'b0) begin
            errors++;
            $display("FAIL %s cause=%h mask=%h req=%b expected 00 00 0",
                     tag, cause_rd, mask_rd, exc_req);
        end
        m_sw = 2'b00; m_mask = 8'h00; m_ten = ben;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Drives one cycle of stimulus at a falling edge and queues the expectation
    task automatic drive(input logic [4:0] p, input logic s, input logic t,
                         input logic ben, input logic we, input logic sel,
                         input logic [7:0] d, input string tag);
        exp_t e;
        logic [7:0] c;
        pin_irq_n = p; sys_irq_n = s; timer_irq = t; boot_timer_en = ben;
        wr_en = we; wr_sel = sel; wr_data = d;
        if (we && !sel) m_sw = d[1:0];
        if (we && sel)  m_mask = d;
        c[7] = ~p[4] | (t & m_ten);
        c[6] = ~p[3];
        c[5] = ~s;
        c[4] = ~p[2];
        c[3] = ~p[1];
        c[2] = ~p[0];
        c[1:0] = m_sw;
        e.cause = c; e.mask = m_mask; e.req = |(c & m_mask); e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compares just after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cause_rd !== e.cause || mask_rd !== e.mask || exc_req !== e.req) begin
                errors++;
                $display("FAIL %s cause=%h mask=%h req=%b expected %h %h %b",
                         e.tag, cause_rd, mask_rd, exc_req, e.cause, e.mask, e.req);
            end
        end
    end

    initial begin
        #(CLK_PERIOD*20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1, "R9 reset, timer on");
        drive(5'h1f, 1, 0, 1, 0, 0, 8'h00, "R10 idle");
        drive(5'h1e, 1, 0, 1, 0, 0, 8'h00, "R4 int0 unmasked");
        drive(5'h1f, 1, 0, 1, 1, 1, 8'h04, "R6 mask bit 10");
        drive(5'h1e, 1, 0, 1, 0, 0, 8'h00, "R7 int0 masked on");
        drive(5'h1d, 1, 0, 1, 0, 0, 8'h00, "R4 int1 not in mask");
        drive(5'h1b, 1, 0, 1, 0, 0, 8'h00, "R4 int2");
        drive(5'h17, 1, 0, 1, 1, 1, 8'h40, "R2 int4 masked");
        drive(5'h1f, 0, 0, 1, 1, 1, 8'h20, "R3 internal line");
        drive(5'h1f, 1, 0, 1, 1, 1, 8'h80, "R1 mask bit 15");
        drive(5'h0f, 1, 0, 1, 0, 0, 8'h00, "R1 int5 pin");
        drive(5'h1f, 1, 1, 1, 0, 0, 8'h00, "R1 timer enabled");
        drive(5'h1f, 1, 1, 0, 0, 0, 8'h00, "R8 boot enable dropped after reset");
        drive(5'h1f, 1, 0, 0, 1, 0, 8'hfd, "R5 cause write upper bits ignored");
        drive(5'h1f, 1, 0, 0, 0, 0, 8'h00, "R5 sw bits hold");
        drive(5'h1f, 1, 0, 0, 1, 1, 8'h01, "R7 sw bit 8 masked");
        drive(5'h1f, 1, 0, 0, 1, 0, 8'h02, "R5 sw bit 9 only");
        drive(5'h1f, 1, 0, 0, 1, 1, 8'h02, "R7 sw bit 9 masked");
        drive(5'h00, 0, 1, 0, 1, 1, 8'h00, "R7 all set mask clear");
        drive(5'h00, 0, 1, 0, 1, 0, 8'h00, "R5 sw clear");
        do_reset(1'b0, "R9 reset, timer off");
        drive(5'h1f, 1, 0, 1, 1, 1, 8'hff, "R6 full mask");
        drive(5'h1f, 1, 1, 1, 0, 0, 8'h00, "R8 timer ignored when off at boot");
        drive(5'h0f, 1, 1, 1, 0, 0, 8'h00, "R1 int5 with timer off");
        drive(5'h1f, 1, 0, 1, 1, 0, 8'h03, "R7 both sw bits");
        drive(5'h1f, 1, 0, 1, 0, 0, 8'h00, "R10 settle");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule